// File: doc/BRIEF.md
# Dual-Channel Interrupt Cause Controller

This block keeps the interrupt cause and interrupt mask state for two engine channels. Both channels share one cause register and one mask register, each 32 bits wide. Channel n owns the 16-bit half at bits [16n+15:16n] in both registers. Each channel sends single-cycle event pulses, one bit per cause. A pulsed bit is latched into that channel's half of the cause register and stays set until software clears it.

Cause bits are cleared by writing zero. A written 0 clears the matching cause bit and a written 1 leaves it as it is. A channel acknowledges its own events by writing a word that has zeros only at the bits it wants cleared and ones everywhere else, so the other channel's half is left alone. The mask register is a plain read/write register. For each channel the block drives a registered interrupt line and a registered fatal-error line. The fatal-error line combines error causes 5 to 9 of that channel and leaves out the non-fatal cause 4.

Top module: `icc_dual_cause`

## Requirements
- R1: After a synchronous reset, cause_o, mask_o, irq_o and fatal_o are all zero.
- R2: Event bit k of channel n (evt_i[16n+k]) sets cause bit 16n+k at the clock edge where it is sampled, and it sets no bit in the other channel's half.
- R3: A cause write clears every cause bit whose wdata_i bit is 0, at the edge where the write is sampled.
- R4: A cause write leaves every cause bit whose wdata_i bit is 1 unchanged. Without a cause write, no cause bit ever falls.
- R5: A mask write stores all 32 bits of wdata_i into mask_o. A mask holding a channel's pattern shifted left by 16n enables interrupts from that channel only.
- R6: irq_o[n] equals the OR over field n of (cause AND mask). It takes the new value one clock edge after the register change, so in the first cycle after the change it still shows the old value.
- R7: When an event pulse and a write-zero clear hit the same cause bit in the same cycle, the bit ends up set.
- R8: fatal_o[n] equals the OR of cause bits 5 to 9 of channel n, registered one edge after the cause register. Cause bit 4 (non-fatal error) and bits outside 4..9 have no effect on it, and the mask does not gate it.
- R9: Writing a word that is all ones except bit 16n clears only end-of-chain cause bit 0 of channel n. Every other cause bit of both channels is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 32 | Event pulses, 16 per channel, channel n at [16n+15:16n] |
| cause_wr_i | input | 1 | Write strobe for the cause register (write-zero-to-clear) |
| mask_wr_i | input | 1 | Write strobe for the mask register |
| wdata_i | input | 32 | Write data shared by both registers |
| cause_o | output | 32 | Current cause register |
| mask_o | output | 32 | Current mask register |
| irq_o | output | 2 | Registered interrupt line per channel |
| fatal_o | output | 2 | Registered fatal-error line per channel |

## Verification
A cause bit in the wrong state shows up on cause_o right after the edge that should have set, kept or cleared it. On irq_o or fatal_o it shows up one edge later. A fault in the half-word split shows up as a set or cleared bit in the wrong channel's half on the first event or acknowledge. A fault in the mask shows on irq_o one edge after the write. The tests therefore compare cause_o right after each event or write, and compare the flag lines both in the cycle before they are due to update and in the cycle after.

// File: rtl/icc_pkg.sv
package icc_pkg;

    // Width of one channel's half of the shared registers
    localparam int FIELD_W     = 16;
    // Error cause range inside a channel field
    localparam int ERR_LO      = 4;
    localparam int ERR_HI      = 9;
    // Error cause that never counts as fatal
    localparam int NONFATAL_IX = 4;
    // End-of-chain cause position
    localparam int EOC_IX      = 0;

    typedef logic [FIELD_W-1:0] field_t;

    typedef struct packed {
        logic irq;
        logic fatal;
    } ch_flags_t;

    // Bits of a field that contribute to the fatal indication
    function automatic field_t fatal_sel();
        field_t m;
        m = '0;
        for (int i = ERR_LO; i <= ERR_HI; i++) begin
            if (i != NONFATAL_IX) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Next cause value: the keep mask removes bits written as zero, new events win
    function automatic field_t cause_next(field_t cur, field_t keep, field_t evt);
        return (cur & keep) | evt;
    endfunction

endpackage

// File: rtl/icc_cause_field.sv
module icc_cause_field
    import icc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  field_t evt_i,
    input  logic   wr_i,
    input  field_t wdata_i,
    output field_t cause_o
);

    field_t cause_q;
    field_t keep;

    always_comb begin
        keep = wr_i ? wdata_i : '1;
    end

    always_ff @(posedge clk) begin
        if (rst) cause_q <= '0;
        else     cause_q <= cause_next(cause_q, keep, evt_i);
    end

    assign cause_o = cause_q;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> ((cause_q & ~$past(wdata_i) & ~$past(evt_i)) == '0)); // R3

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R4

    AST_KEEP_ONES: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> ((cause_q & $past(cause_q) & $past(wdata_i)) == ($past(cause_q) & $past(wdata_i)))); // R4

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        (evt_i != '0) |=> ((cause_q & $past(evt_i)) == $past(evt_i))); // R7

endmodule

// File: rtl/icc_mask_field.sv
module icc_mask_field
    import icc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_i,
    input  field_t wdata_i,
    output field_t mask_o
);

    field_t mask_q;

    always_ff @(posedge clk) begin
        if (rst)       mask_q <= '0;
        else if (wr_i) mask_q <= wdata_i;
    end

    assign mask_o = mask_q;

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (mask_q == $past(wdata_i))); // R5

    AST_MASK_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(mask_q)); // R5

endmodule

// File: rtl/icc_flag_gen.sv
module icc_flag_gen
    import icc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  field_t    cause_i,
    input  field_t    mask_i,
    output ch_flags_t flags_o
);

    localparam field_t FATAL_SEL = fatal_sel();

    ch_flags_t flags_q;
    ch_flags_t flags_d;

    always_comb begin
        flags_d.irq   = |(cause_i & mask_i);
        flags_d.fatal = |(cause_i & FATAL_SEL);
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
        ((cause_i & mask_i) != '0) |=> flags_o.irq); // R6

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((cause_i & mask_i) == '0) |=> !flags_o.irq); // R6

    AST_NONFATAL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        ((cause_i[ERR_HI:ERR_LO+1]) == '0) |=> !flags_o.fatal); // R8

    AST_FATAL_SEEN: assert property (@(posedge clk) disable iff (rst)
        ((cause_i[ERR_HI:ERR_LO+1]) != '0) |=> flags_o.fatal); // R8

endmodule

// File: rtl/icc_dual_cause.sv
module icc_dual_cause
    import icc_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int REG_W = NUM_CH * FIELD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_W-1:0]  evt_i,
    input  logic              cause_wr_i,
    input  logic              mask_wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  cause_o,
    output logic [REG_W-1:0]  mask_o,
    output logic [NUM_CH-1:0] irq_o,
    output logic [NUM_CH-1:0] fatal_o
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam int LO = ch * FIELD_W;

        field_t    cause_f;
        field_t    mask_f;
        ch_flags_t flags;

        icc_cause_field u_cause (
            .clk     (clk),
            .rst     (rst),
            .evt_i   (evt_i[LO +: FIELD_W]),
            .wr_i    (cause_wr_i),
            .wdata_i (wdata_i[LO +: FIELD_W]),
            .cause_o (cause_f)
        );

        icc_mask_field u_mask (
            .clk     (clk),
            .rst     (rst),
            .wr_i    (mask_wr_i),
            .wdata_i (wdata_i[LO +: FIELD_W]),
            .mask_o  (mask_f)
        );

        icc_flag_gen u_flags (
            .clk     (clk),
            .rst     (rst),
            .cause_i (cause_f),
            .mask_i  (mask_f),
            .flags_o (flags)
        );

        assign cause_o[LO +: FIELD_W] = cause_f;
        assign mask_o[LO +: FIELD_W]  = mask_f;
        assign irq_o[ch]   = flags.irq;
        assign fatal_o[ch] = flags.fatal;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (cause_o == '0 && mask_o == '0 && irq_o == '0 && fatal_o == '0)); // R1

    AST_EOC_ACK_SCOPE: assert property (@(posedge clk) disable iff (rst)
        (cause_wr_i && evt_i == '0 && wdata_i == ~{{(REG_W-1){1'b0}}, 1'b1})
        |=> (cause_o == ($past(cause_o) & ~{{(REG_W-1){1'b0}}, 1'b1}))); // R9

endmodule

// File: tb/icc_dual_cause_test.sv
module icc_dual_cause_test;

    localparam int NCH = 2;
    localparam int RW  = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic [RW-1:0]   evt;
    logic            cause_wr;
    logic            mask_wr;
    logic [RW-1:0]   wdata;
    logic [RW-1:0]   cause;
    logic [RW-1:0]   mask;
    logic [NCH-1:0]  irq;
    logic [NCH-1:0]  fatal;

    int total = 0;
    int bad   = 0;

    logic [RW-1:0] m_cause;
    logic [RW-1:0] m_mask;

    always #2 clk = ~clk;

    icc_dual_cause uut (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .cause_wr_i (cause_wr),
        .mask_wr_i  (mask_wr),
        .wdata_i    (wdata),
        .cause_o    (cause),
        .mask_o     (mask),
        .irq_o      (irq),
        .fatal_o    (fatal)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [NCH-1:0] exp_irq();
        logic [NCH-1:0] r;
        for (int c = 0; c < NCH; c++) r[c] = |(m_cause[c*16 +: 16] & m_mask[c*16 +: 16]);
        return r;
    endfunction

    function automatic logic [NCH-1:0] exp_fatal();
        logic [NCH-1:0] r;
        for (int c = 0; c < NCH; c++) r[c] = |(m_cause[c*16 +: 16] & 16'h03E0);
        return r;
    endfunction

    // one cycle: optional events, optional cause write, optional mask write
    task automatic step(logic [31:0] e, logic cw, logic mw, logic [31:0] d);
        evt = e; cause_wr = cw; mask_wr = mw; wdata = d;
        tick();
        evt = '0; cause_wr = 1'b0; mask_wr = 1'b0; wdata = '0;
        if (cw) m_cause = m_cause & d;
        m_cause = m_cause | e;
        if (mw) m_mask = d;
    endtask

    task automatic check_flags(string req);
        tick();
        check(req, "irq",   {30'd0, irq},   {30'd0, exp_irq()});
        check(req, "fatal", {30'd0, fatal}, {30'd0, exp_fatal()});
    endtask

    task automatic t_reset();
        check("R1", "cause", cause, 32'h0);
        check("R1", "mask",  mask,  32'h0);
        check("R1", "irq",   {30'd0, irq},   32'h0);
        check("R1", "fatal", {30'd0, fatal}, 32'h0);
    endtask

    task automatic t_fields();
        step(32'h0101_0003, 1'b0, 1'b0, 32'h0);
        check("R2", "cause after events", cause, 32'h0101_0003);
        check_flags("R8");   // ch1 bit 8 is fatal, mask zero keeps irq low
        check("R6", "irq masked off", {30'd0, irq}, 32'h0);
        check("R4", "no write holds", cause, 32'h0101_0003);
    endtask

    task automatic t_eoc_ack();
        step(32'h0, 1'b1, 1'b0, 32'hFFFE_FFFF);
        check("R9", "ch1 eoc ack", cause, 32'h0100_0003);
        step(32'h0, 1'b1, 1'b0, 32'hFFFF_FFFE);
        check("R9", "ch0 eoc ack", cause, 32'h0100_0002);
        step(32'h0, 1'b1, 1'b0, 32'hFFFF_FFFF);
        check("R4", "all ones keeps", cause, 32'h0100_0002);
    endtask

    task automatic t_mask();
        step(32'h0, 1'b0, 1'b1, 32'h0100_0000);
        check("R5", "mask stored", mask, 32'h0100_0000);
        check("R6", "irq one cycle late", {30'd0, irq}, 32'h0);
        check_flags("R6");
        check("R5", "only ch1 enabled", {30'd0, irq}, 32'h2);
        step(32'h0, 1'b0, 1'b1, 32'h0000_0002);
        check_flags("R5");
        check("R5", "only ch0 enabled", {30'd0, irq}, 32'h1);
    endtask

    task automatic t_collide();
        step(32'h0000_0004, 1'b1, 1'b0, 32'h0000_0000);
        check("R7", "event beats clear", cause, 32'h0000_0004);
        check("R3", "zeros cleared rest", cause & ~32'h4, 32'h0);
        check_flags("R3");
    endtask

    task automatic t_nonfatal();
        step(32'h0400_0010, 1'b0, 1'b0, 32'h0);
        check("R2", "ch0 bit4 ch1 bit10", cause, 32'h0400_0014);
        check_flags("R8");
        check("R8", "bit4 and bit10 not fatal", {30'd0, fatal}, 32'h0);
        step(32'h0000_0200, 1'b0, 1'b0, 32'h0);
        check_flags("R8");
        check("R8", "bit9 fatal ch0", {30'd0, fatal}, 32'h1);
        step(32'h0, 1'b1, 1'b0, 32'hFFFF_FDFF);
        check("R3", "clear bit9", cause, 32'h0400_0014);
        check_flags("R8");
        step(32'h0, 1'b1, 1'b0, 32'h0);
        check("R3", "clear all", cause, 32'h0);
        check_flags("R6");
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; evt = '0; cause_wr = 1'b0; mask_wr = 1'b0; wdata = '0;
        m_cause = '0; m_mask = '0;
        repeat (3) tick();
        rst = 1'b0;
        t_reset();
        t_fields();
        t_eoc_ack();
        t_mask();
        t_collide();
        t_nonfatal();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule